// File: doc/BRIEF.md
# USB Device Suspend/Resume Mode Controller

This block is the power-mode control register of a USB device controller, together with the timing logic that acts on it. Firmware writes one 8-bit mode byte through a simple synchronous write port. That byte chooses how the device leaves and enters the low-power suspend state. It sets whether the oscillator/PLL clock is stopped while suspended, and whether a chip-select strobe may wake the device. It also drives a power switch for external parts, connects the D+ pull-up, and enables interrupts as a whole. The data bus is 8 or 16 bits wide; only the low byte carries meaning.

Three bits of the byte are commands: go-suspend, send-resume and soft-reset. Each acts only when firmware first writes it to 1 and then writes it to 0, so a single stray write cannot trigger it. Resume signalling and clock stopping are timed against an external millisecond tick. A USB bus reset clears the command and wake controls. It keeps the interrupt enable, the power-off enable and the pull-up connect bit, so the host-visible connection survives the bus reset.

Top module: `usb_pwr_mode_ctrl`

## Requirements
- R1: After the asynchronous hardware reset (rst_n low), the mode byte reads 0x00, the upper read byte is 0, soft_rst_pulse, resume_drive, suspended, susp_pwr, pullup_en and irq_global_en are 0, and clk_en is 1.
- R2: A write (wr_en high at a clock edge) stores wr_data[7:0] into the mode byte, readable on rd_data[7:0] from that edge. With a 16-bit bus, wr_data[15:8] is ignored and rd_data[15:8] reads 0. The bit map is: 7 clock-always-on, 6 send-resume, 5 go-suspend, 4 soft-reset, 3 interrupt-enable, 2 wake-on-chip-select, 1 power-off-enable, 0 pull-up connect.
- R3: bus_rst high at an edge clears mode bits 7, 6, 5, 4 and 2 at that edge and leaves bits 3, 1 and 0 unchanged. A write in the same cycle is stored before the clearing and triggers no command.
- R4: A command bit (6, 5 or 4) acts only when a write changes it from a stored 1 to a written 0. Writing it to 1, or writing 0 over a 0, has no effect.
- R5: A go-suspend command stored at edge E sets suspended at edge E+1. A go-suspend command while already suspended is ignored.
- R6: While suspended with bit 7 at 0, clk_en falls at the edge that samples the 2nd ms_tick after suspend entry. With bit 7 at 1, clk_en stays 1. clk_en is 1 whenever the device is not suspended.
- R7: susp_pwr is 1 exactly when suspended is 1 and bit 1 is 1.
- R8: While suspended with bit 2 at 1, cs_n low at an edge clears suspended and sets clk_en to 1 at that edge.
- R9: A send-resume command stored at edge E clears suspended and raises clk_en at E+1. resume_drive then rises at the edge that samples the 5th following ms_tick and falls at the edge that samples the 15th, so it is high for 10 ticks. A new command while a resume sequence is running is ignored.
- R10: A soft-reset command stored at edge E drives soft_rst_pulse high for exactly the one cycle after E. At E+1 the mode byte, the suspend state and the resume timer return to their R1 values.
- R11: pullup_en equals mode bit 0 and irq_global_en equals mode bit 3 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for the mode byte |
| wr_data | input | DATA_W | Write data; only bits 7:0 are used |
| rd_data | output | DATA_W | Mode byte read-back, upper bits 0 |
| bus_rst | input | 1 | USB bus reset event, one cycle per event |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| cs_n | input | 1 | Chip select, active low, already synchronised |
| soft_rst_pulse | output | 1 | One-cycle software reset pulse |
| resume_drive | output | 1 | Upstream resume signalling enable |
| suspended | output | 1 | Device is in suspend state |
| clk_en | output | 1 | Oscillator/PLL clock enable |
| susp_pwr | output | 1 | External power switch control, high while suspended |
| pullup_en | output | 1 | D+ pull-up connect |
| irq_global_en | output | 1 | Global interrupt enable |

## Verification
The hardest state to reach from the ports is a suspended device whose clock has already stopped. Another is a suspended device with chip-select wake armed, where a later event must bring it back. The stimulus reaches these through chains of writes: a go-suspend 1-then-0 pair, ms ticks counted up to the clock-stop point, then a write that arms wake without creating a falling command bit, and finally the cs_n strobe or a send-resume pair. The soft-reset check runs from a suspended state, so that the clearing of suspend and timer state shows at the ports.

// File: rtl/usb_pm_pkg.sv
package usb_pm_pkg;

    localparam int MODE_W = 8;

    // mode byte bit positions
    localparam int B_CLK_ON   = 7;
    localparam int B_RESUME   = 6;
    localparam int B_SUSPEND  = 5;
    localparam int B_SRST     = 4;
    localparam int B_IRQ_EN   = 3;
    localparam int B_CS_WAKE  = 2;
    localparam int B_PWR_OFF  = 1;
    localparam int B_PULLUP   = 0;

    // bits that survive a USB bus reset
    localparam logic [MODE_W-1:0] BUSRST_KEEP =
        MODE_W'((1 << B_IRQ_EN) | (1 << B_PWR_OFF) | (1 << B_PULLUP));

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_WAIT  = 2'd1,
        RS_DRIVE = 2'd2
    } resume_st_e;

endpackage

// File: rtl/upm_mode_reg.sv
module upm_mode_reg
    import usb_pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_byte,
    input  logic              bus_rst,
    output logic [MODE_W-1:0] mode,
    output logic              go_susp_p,
    output logic              send_res_p,
    output logic              srst_p
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              go_susp;
        logic              send_res;
        logic              srst;
    } mreg_s;

    localparam mreg_s MREG_RST = '{mode: '0, go_susp: 1'b0, send_res: 1'b0, srst: 1'b0};

    mreg_s q, d;

    // falling command bit: stored 1, written 0
    function automatic logic falls(input logic [MODE_W-1:0] old_v,
                                   input logic [MODE_W-1:0] new_v,
                                   input int unsigned       idx);
        return old_v[idx] & ~new_v[idx];
    endfunction

    always_comb begin
        d          = q;
        d.go_susp  = 1'b0;
        d.send_res = 1'b0;
        d.srst     = 1'b0;
        if (q.srst) begin
            // the reset pulse cycle clears everything
            d = MREG_RST;
        end else begin
            if (wr_en) begin
                d.mode = wr_byte;
                if (!bus_rst) begin
                    d.go_susp  = falls(q.mode, wr_byte, B_SUSPEND);
                    d.send_res = falls(q.mode, wr_byte, B_RESUME);
                    d.srst     = falls(q.mode, wr_byte, B_SRST);
                end
            end
            if (bus_rst) begin
                d.mode = d.mode & BUSRST_KEEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= MREG_RST;
        end else begin
            q <= d;
        end
    end

    assign mode       = q.mode;
    assign go_susp_p  = q.go_susp;
    assign send_res_p = q.send_res;
    assign srst_p     = q.srst;

endmodule

// File: rtl/upm_suspend.sv
module upm_suspend #(
    parameter int CLKSTOP_MS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic go_p,
    input  logic res_p,
    input  logic clk_always_on,
    input  logic cs_wake_en,
    input  logic cs_n,
    input  logic ms_tick,
    output logic suspended,
    output logic clk_en
);

    localparam int CNT_W = (CLKSTOP_MS < 2) ? 1 : $clog2(CLKSTOP_MS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKSTOP_MS - 1);

    typedef struct packed {
        logic             susp;
        logic             clk_on;
        logic [CNT_W-1:0] cnt;
    } susp_s;

    localparam susp_s SUSP_RST = '{susp: 1'b0, clk_on: 1'b1, cnt: '0};

    susp_s q, d;
    logic  wake;

    always_comb begin
        wake = res_p | (q.susp & cs_wake_en & ~cs_n);
        d    = q;
        if (clear) begin
            d = SUSP_RST;
        end else if (wake) begin
            d = SUSP_RST;
        end else if (go_p && !q.susp) begin
            d.susp   = 1'b1;
            d.clk_on = 1'b1;
            d.cnt    = '0;
        end else if (q.susp) begin
            if (clk_always_on) begin
                d.clk_on = 1'b1;
                d.cnt    = '0;
            end else if (q.clk_on && ms_tick) begin
                if (q.cnt == CNT_LAST) begin
                    d.clk_on = 1'b0;
                    d.cnt    = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SUSP_RST;
        end else begin
            q <= d;
        end
    end

    assign suspended = q.susp;
    assign clk_en    = q.clk_on;

endmodule

// File: rtl/upm_resume.sv
module upm_resume
    import usb_pm_pkg::*;
#(
    parameter int DELAY_MS = 5,
    parameter int LEN_MS   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    input  logic ms_tick,
    output logic drive
);

    localparam int MAX_MS = (DELAY_MS > LEN_MS) ? DELAY_MS : LEN_MS;
    localparam int CNT_W  = (MAX_MS < 2) ? 1 : $clog2(MAX_MS);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(DELAY_MS - 1);
    localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(LEN_MS - 1);

    typedef struct packed {
        resume_st_e       st;
        logic [CNT_W-1:0] cnt;
    } res_s;

    localparam res_s RES_RST = '{st: RS_IDLE, cnt: '0};

    res_s q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d = RES_RST;
        end else begin
            unique case (q.st)
                RS_IDLE: begin
                    if (start) begin
                        d.st  = RS_WAIT;
                        d.cnt = '0;
                    end
                end
                RS_WAIT: begin
                    if (ms_tick) begin
                        if (q.cnt == WAIT_LAST) begin
                            d.st  = RS_DRIVE;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                RS_DRIVE: begin
                    if (ms_tick) begin
                        if (q.cnt == DRIVE_LAST) begin
                            d = RES_RST;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d = RES_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RES_RST;
        end else begin
            q <= d;
        end
    end

    assign drive = (q.st == RS_DRIVE);

endmodule

// File: rtl/usb_pwr_mode_ctrl.sv
module usb_pwr_mode_ctrl
    import usb_pm_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int RES_DLY_MS = 5,
    parameter int RES_LEN_MS = 10,
    parameter int CLKSTOP_MS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              bus_rst,
    input  logic              ms_tick,
    input  logic              cs_n,
    output logic              soft_rst_pulse,
    output logic              resume_drive,
    output logic              suspended,
    output logic              clk_en,
    output logic              susp_pwr,
    output logic              pullup_en,
    output logic              irq_global_en
);

    logic [MODE_W-1:0] mode;
    logic              go_susp_p;
    logic              send_res_p;
    logic              srst_p;

    generate
        if (DATA_W > MODE_W) begin : g_wide
            logic wr_hi_unused;
            assign wr_hi_unused = ^wr_data[DATA_W-1:MODE_W];
        end
    endgenerate

    upm_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_byte    (wr_data[MODE_W-1:0]),
        .bus_rst    (bus_rst),
        .mode       (mode),
        .go_susp_p  (go_susp_p),
        .send_res_p (send_res_p),
        .srst_p     (srst_p)
    );

    upm_suspend #(.CLKSTOP_MS(CLKSTOP_MS)) u_susp (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (srst_p),
        .go_p          (go_susp_p),
        .res_p         (send_res_p),
        .clk_always_on (mode[B_CLK_ON]),
        .cs_wake_en    (mode[B_CS_WAKE]),
        .cs_n          (cs_n),
        .ms_tick       (ms_tick),
        .suspended     (suspended),
        .clk_en        (clk_en)
    );

    upm_resume #(.DELAY_MS(RES_DLY_MS), .LEN_MS(RES_LEN_MS)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (srst_p),
        .start   (send_res_p),
        .ms_tick (ms_tick),
        .drive   (resume_drive)
    );

    always_comb begin
        rd_data             = '0;
        rd_data[MODE_W-1:0] = mode;
    end

    assign soft_rst_pulse = srst_p;
    assign susp_pwr       = suspended & mode[B_PWR_OFF];
    assign pullup_en      = mode[B_PULLUP];
    assign irq_global_en  = mode[B_IRQ_EN];

endmodule

// File: rtl/upm_checker.sv
module upm_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              bus_rst,
    input logic              cs_n,
    input logic              soft_rst_pulse,
    input logic              resume_drive,
    input logic              suspended,
    input logic              clk_en,
    input logic              susp_pwr
);

    a_r10_srst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> !soft_rst_pulse);

    a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> (rd_data == '0 && !suspended && !resume_drive && clk_en));

    a_r7_pwr_only_suspended: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pwr |-> suspended);

    a_r6_clk_on_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !suspended |-> clk_en);

    a_r3_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (rd_data[7:4] == 4'b0 && rd_data[2] == 1'b0));

    a_r8_cs_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && rd_data[2] && !cs_n) |=> (!suspended && clk_en));

endmodule

bind usb_pwr_mode_ctrl upm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_data        (rd_data),
    .bus_rst        (bus_rst),
    .cs_n           (cs_n),
    .soft_rst_pulse (soft_rst_pulse),
    .resume_drive   (resume_drive),
    .suspended      (suspended),
    .clk_en         (clk_en),
    .susp_pwr       (susp_pwr)
);

// File: tb/usb_pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module usb_pwr_mode_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        bus_rst = 1'b0;
    logic        ms_tick = 1'b0;
    logic        cs_n = 1'b1;
    logic        soft_rst_pulse, resume_drive, suspended, clk_en;
    logic        susp_pwr, pullup_en, irq_global_en;

    always #4 clk = ~clk;

    usb_pwr_mode_ctrl #(.DATA_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bus_rst(bus_rst), .ms_tick(ms_tick), .cs_n(cs_n),
        .soft_rst_pulse(soft_rst_pulse), .resume_drive(resume_drive),
        .suspended(suspended), .clk_en(clk_en), .susp_pwr(susp_pwr),
        .pullup_en(pullup_en), .irq_global_en(irq_global_en)
    );

    // observation vector
    localparam logic [15:0] M_RD    = 16'h00FF;
    localparam logic [15:0] M_PULSE = 16'h0100;
    localparam logic [15:0] M_DRIVE = 16'h0200;
    localparam logic [15:0] M_SUSP  = 16'h0400;
    localparam logic [15:0] M_CLK   = 16'h0800;
    localparam logic [15:0] M_PWR   = 16'h1000;
    localparam logic [15:0] M_PULL  = 16'h2000;
    localparam logic [15:0] M_GIE   = 16'h4000;
    localparam logic [15:0] M_HI    = 16'h8000;

    logic [15:0] obs;
    assign obs = {(rd_data[15:8] != 8'h00), irq_global_en, pullup_en, susp_pwr,
                  clk_en, suspended, resume_drive, soft_rst_pulse, rd_data[7:0]};

    typedef struct {
        int          cyc;
        logic [15:0] mask;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int dly, input string req,
                             input logic [15:0] mask, input logic [15:0] exp);
        item_t it;
        it.cyc  = cyc + dly;
        it.mask = mask;
        it.exp  = exp;
        it.req  = req;
        sbq.push_back(it);
    endtask

    // monitor: compares queued expectations in the cycle they target
    always @(negedge clk) begin
        item_t it;
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            it = sbq.pop_front();
            checks++;
            if (it.cyc < cyc) begin
                errors++;
                $display("FAIL %s stale expectation cyc %0d got %h exp %h",
                         it.req, it.cyc, obs & it.mask, it.exp & it.mask);
            end else if ((obs & it.mask) !== (it.exp & it.mask)) begin
                errors++;
                $display("FAIL %s cyc %0d got %h exp %h",
                         it.req, cyc, obs & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic wr(input logic [15:0] v);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        ms_tick = 1'b1;
        @(posedge clk); #1;
        ms_tick = 1'b0;
    endtask

    task automatic cs_strobe();
        @(posedge clk); #1;
        cs_n = 1'b0;
        @(posedge clk); #1;
        cs_n = 1'b1;
    endtask

    task automatic busrst();
        @(posedge clk); #1;
        bus_rst = 1'b1;
        @(posedge clk); #1;
        bus_rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        expect_at(0, "R1", 16'hFFFF, M_CLK);
        @(posedge clk); #1;

        // R2 / R11: write with upper byte garbage, pull-up and irq enable
        wr(16'hA509);
        expect_at(0, "R2", 16'hFFFF, M_CLK | M_PULL | M_GIE | 16'h0009);

        // R4: go-suspend written to 1 only -> nothing
        wr(16'h002B);
        expect_at(0, "R4", M_RD | M_SUSP, 16'h002B);
        expect_at(1, "R4", M_SUSP, 16'h0000);
        // R5 / R7: 1 then 0 enters suspend, power switch follows bit 1
        wr(16'h000B);
        expect_at(0, "R5", M_RD | M_SUSP, 16'h000B);
        expect_at(1, "R5", M_SUSP | M_PWR | M_CLK, M_SUSP | M_PWR | M_CLK);

        // R6: clock stops on the 2nd tick
        tick();
        expect_at(0, "R6", M_CLK | M_SUSP, M_CLK | M_SUSP);
        tick();
        expect_at(0, "R6", M_CLK | M_SUSP, M_SUSP);

        // R8: arm chip-select wake, then strobe
        wr(16'h000F);
        expect_at(0, "R8", M_RD | M_SUSP | M_CLK, 16'h000F | M_SUSP);
        cs_strobe();
        expect_at(0, "R8", M_SUSP | M_CLK | M_PWR, M_CLK);

        // R3: bus reset keeps bits 3,1,0
        wr(16'h00FF);
        expect_at(0, "R3", M_RD | M_SUSP, 16'h00FF);
        busrst();
        expect_at(0, "R3", M_RD | M_SUSP | M_PULL | M_GIE, 16'h000B | M_PULL | M_GIE);

        // R6: clock-always-on keeps clk_en high while suspended
        wr(16'h00AB);
        wr(16'h008B);
        expect_at(1, "R6", M_SUSP | M_CLK | M_PWR, M_SUSP | M_CLK | M_PWR);
        for (int i = 0; i < 3; i++) begin
            tick();
            expect_at(0, "R6", M_SUSP | M_CLK, M_SUSP | M_CLK);
        end

        // R9: send-resume wakes, then 5 ms wait and 10 ms drive
        wr(16'h00CB);
        wr(16'h008B);
        expect_at(1, "R9", M_SUSP | M_CLK | M_DRIVE, M_CLK);
        for (int i = 1; i <= 15; i++) begin
            tick();
            expect_at(0, "R9", M_DRIVE, (i >= 5 && i <= 14) ? M_DRIVE : 16'h0000);
        end

        // R10: soft reset from a suspended state
        wr(16'h002B);
        wr(16'h000B);
        expect_at(1, "R10", M_SUSP, M_SUSP);
        wr(16'h001B);
        expect_at(0, "R4", M_PULSE | M_SUSP, M_SUSP);
        wr(16'h000B);
        expect_at(0, "R10", M_PULSE | M_RD, M_PULSE | 16'h000B);
        expect_at(1, "R10", 16'hFFFF, M_CLK);

        repeat (4) @(posedge clk);
        finished = 1'b1;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard left %0d got %0d exp %0d", sbq.size(), sbq.size(), 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog expired got %0d exp %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule